// File: doc/BRIEF.md
# Byte Programming Pulse Sequencer

This block steps a byte-wide one-time-programmable memory through its write procedure. A host gives it an address, a data byte and a target (main array byte, key-array byte or lock bit) and pulses a start request. The sequencer latches the request and drives the address, the data and a one-hot mode code to the memory. After a setup delay it raises the programming-voltage enable, waits again, and then issues a train of active-low programming pulses. The pulse count depends on the target. After the last pulse it holds the voltage enable for a further delay, drops it, and pulses done, so the host can queue the next byte. Repeating this byte by byte writes a whole image.

A start request is refused when a lock-level inhibit input is high or the target code is not defined. A refused request gives a one-cycle refusal pulse and never touches the programming-voltage enable or the pulse line. When the sequencer is idle, a separate verify request presents an address and gives a one-cycle active-low read strobe. Setup, pulse width, inter-pulse gap and hold are fixed cycle counts, set by parameters.

Top module: `prog_sequencer`

## Requirements
- R1: After synchronous reset, busy_o, done_o, refused_o and vpp_en_o are 0, prog_n_o and vfy_rd_n_o are 1, and mode_o is 0.
- R2: An accepted start presents addr_o, data_o and mode_o for SETUP_CYC cycles with vpp_en_o low. vpp_en_o is then high for SETUP_CYC cycles before the first low cycle of prog_n_o.
- R3: Target code 0 (main array) produces exactly MAIN_PULSES (default 5) low pulses on prog_n_o.
- R4: Target code 1 (key array) and code 2 (lock bit) each produce exactly KEY_PULSES (default 25) low pulses on prog_n_o.
- R5: Each pulse holds prog_n_o low for PULSE_CYC cycles, and consecutive pulses are separated by GAP_CYC high cycles. prog_n_o is low only while busy_o is high.
- R6: vpp_en_o is high in every cycle in which prog_n_o is low, and stays high for HOLD_CYC cycles after the last pulse. addr_o and data_o keep the latched values for the whole busy period.
- R7: done_o is high for exactly one cycle, which is the last busy cycle. busy_o lasts 2*SETUP_CYC + N*PULSE_CYC + (N-1)*GAP_CYC + HOLD_CYC + 1 cycles for N pulses.
- R8: A start request that arrives while busy_o is high is ignored. The latched address, data and pulse count are kept.
- R9: A start request with lock_inhibit_i high or target code 3 gives refused_o high for one cycle and busy_o stays low. No vpp_en_o and no pulse follow.
- R10: A verify request while idle drives vfy_rd_n_o low for one cycle, with addr_o set to the requested address, and vpp_en_o stays low.
- R11: mode_o is one-hot while busy: bit 0 for the main array, bit 1 for the key array, bit 2 for a lock bit. It is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to program one byte |
| tgt_i | input | 2 | Target: 0 main, 1 key, 2 lock, 3 undefined |
| lock_inhibit_i | input | 1 | Programming disabled by lock level |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Byte to write |
| vfy_req_i | input | 1 | Verify read request |
| addr_o | output | ADDR_W | Address driven to the memory |
| data_o | output | DATA_W | Data driven to the memory |
| mode_o | output | 3 | One-hot mode code |
| vpp_en_o | output | 1 | Programming-voltage enable |
| prog_n_o | output | 1 | Active-low programming pulse |
| vfy_rd_n_o | output | 1 | Active-low verify read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| refused_o | output | 1 | One-cycle refused-start pulse |

## Verification
Every output is registered or comes from registered state. A start, verify or refused request sampled at one edge therefore shows its effect in the cycle that follows: busy, mode, address and data, the read strobe, or the refusal pulse. Later phase boundaries fall a fixed number of cycles apart: SETUP_CYC, SETUP_CYC, PULSE_CYC and GAP_CYC per pulse, then HOLD_CYC, then one done cycle. The bench samples once per cycle on the falling clock edge. It measures every phase length by counting consecutive samples and compares each length with the figure derived from the parameters. Because of this, an error of a single cycle in any phase is caught.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [1:0] {
        TGT_MAIN = 2'd0,
        TGT_KEY  = 2'd1,
        TGT_LOCK = 2'd2,
        TGT_NONE = 2'd3
    } target_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_RAMP,
        PH_PULSE,
        PH_GAP,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic lock;
        logic key;
        logic main;
    } mode_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/prog_cycle_timer.sv
module prog_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prog_pulse_tally.sv
module prog_pulse_tally #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prog_target_decode.sv
module prog_target_decode
    import prog_seq_pkg::*;
#(
    parameter int MAIN_PULSES = 5,
    parameter int KEY_PULSES  = 25,
    parameter int CNT_W       = 5
) (
    input  target_e          tgt,
    output mode_t            mode,
    output logic [CNT_W-1:0] pulses,
    output logic             valid
);
    always_comb begin
        mode   = '0;
        pulses = CNT_W'(KEY_PULSES);
        valid  = 1'b1;
        case (tgt)
            TGT_MAIN: begin mode.main = 1'b1; pulses = CNT_W'(MAIN_PULSES); end
            TGT_KEY:  mode.key  = 1'b1;
            TGT_LOCK: mode.lock = 1'b1;
            default:  valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 48,
    parameter int PULSE_CYC   = 16,
    parameter int GAP_CYC     = 48,
    parameter int HOLD_CYC    = 48,
    parameter int MAIN_PULSES = 5,
    parameter int KEY_PULSES  = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        tgt_i,
    input  logic              lock_inhibit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              vfy_req_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [2:0]        mode_o,
    output logic              vpp_en_o,
    output logic              prog_n_o,
    output logic              vfy_rd_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              refused_o
);
    localparam int LIM_MAX = max_of4(SETUP_CYC, PULSE_CYC, GAP_CYC, HOLD_CYC);
    localparam int TIM_W   = $clog2(LIM_MAX + 1);
    localparam int PMAX    = (KEY_PULSES > MAIN_PULSES) ? KEY_PULSES : MAIN_PULSES;
    localparam int TAL_W   = $clog2(PMAX + 1);

    phase_e             phase, phase_nx;
    logic [TIM_W-1:0]   tcnt;
    logic [TAL_W-1:0]   pcnt, need_q, need_dec;
    mode_t              mode_q, mode_dec;
    logic               tgt_ok;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               refused_q, rd_n_q;
    int                 lim;
    logic               tick, last_pulse, idle, accept, refuse;

    prog_target_decode #(
        .MAIN_PULSES(MAIN_PULSES), .KEY_PULSES(KEY_PULSES), .CNT_W(TAL_W)
    ) u_dec (
        .tgt(target_e'(tgt_i)), .mode(mode_dec), .pulses(need_dec), .valid(tgt_ok)
    );

    prog_cycle_timer #(.CNT_W(TIM_W)) u_timer (
        .clk(clk), .rst(rst), .clr((phase_nx != phase) || idle), .cnt(tcnt)
    );

    prog_pulse_tally #(.CNT_W(TAL_W)) u_tally (
        .clk(clk), .rst(rst), .clr(idle), .inc((phase == PH_PULSE) && tick), .cnt(pcnt)
    );

    assign idle       = (phase == PH_IDLE);
    assign accept     = idle && start_i && tgt_ok && !lock_inhibit_i;
    assign refuse     = idle && start_i && (!tgt_ok || lock_inhibit_i);
    assign tick       = (tcnt == TIM_W'(lim - 1));
    assign last_pulse = (pcnt == need_q - 1'b1);

    always_comb begin
        case (phase)
            PH_SETUP, PH_RAMP: lim = SETUP_CYC;
            PH_PULSE:          lim = PULSE_CYC;
            PH_GAP:            lim = GAP_CYC;
            PH_HOLD:           lim = HOLD_CYC;
            default:           lim = 1;
        endcase
    end

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:  if (accept) phase_nx = PH_SETUP;
            PH_SETUP: if (tick) phase_nx = PH_RAMP;
            PH_RAMP:  if (tick) phase_nx = PH_PULSE;
            PH_PULSE: if (tick) phase_nx = last_pulse ? PH_HOLD : PH_GAP;
            PH_GAP:   if (tick) phase_nx = PH_PULSE;
            PH_HOLD:  if (tick) phase_nx = PH_DONE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            addr_q    <= '0;
            data_q    <= '0;
            need_q    <= '0;
            mode_q    <= '0;
            refused_q <= 1'b0;
            rd_n_q    <= 1'b1;
        end else begin
            phase     <= phase_nx;
            refused_q <= refuse;
            rd_n_q    <= !(idle && vfy_req_i && !start_i);
            if (accept) begin
                addr_q <= addr_i;
                data_q <= data_i;
                need_q <= need_dec;
                mode_q <= mode_dec;
            end else if (idle && vfy_req_i && !start_i) begin
                addr_q <= addr_i;
            end
        end
    end

    assign addr_o     = addr_q;
    assign data_o     = data_q;
    assign busy_o     = !idle;
    assign mode_o     = idle ? 3'b000 : mode_q;
    assign vpp_en_o   = (phase == PH_RAMP) || (phase == PH_PULSE) ||
                        (phase == PH_GAP)  || (phase == PH_HOLD);
    assign prog_n_o   = (phase != PH_PULSE);
    assign done_o     = (phase == PH_DONE);
    assign refused_o  = refused_q;
    assign vfy_rd_n_o = rd_n_q;
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 8,
    parameter int MAIN_PULSES = 5,
    parameter int KEY_PULSES  = 25
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic [2:0]        mode_o,
    input logic              vpp_en_o,
    input logic              prog_n_o,
    input logic              vfy_rd_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              refused_o
);
    logic [15:0] fall_cnt;
    logic        prog_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt <= '0;
            prog_n_d <= 1'b1;
        end else begin
            prog_n_d <= prog_n_o;
            if (!busy_o)                   fall_cnt <= '0;
            else if (prog_n_d && !prog_n_o) fall_cnt <= fall_cnt + 1'b1;
        end
    end

    assert_vpp_covers_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> vpp_en_o);
    assert_pulse_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> busy_o);
    assert_latch_held_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(data_o)));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);
    assert_refuse_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        refused_o |-> (!busy_o && !vpp_en_o));
    assert_verify_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !vfy_rd_n_o |-> (!vpp_en_o && !busy_o));
    assert_mode_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ($countones(mode_o) == 1));
    assert_pulse_total_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (fall_cnt == 16'(MAIN_PULSES) || fall_cnt == 16'(KEY_PULSES)));
endmodule

bind prog_sequencer prog_seq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_PULSES(MAIN_PULSES), .KEY_PULSES(KEY_PULSES)
) u_chk (
    .clk(clk), .rst(rst), .addr_o(addr_o), .data_o(data_o), .mode_o(mode_o),
    .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .vfy_rd_n_o(vfy_rd_n_o),
    .busy_o(busy_o), .done_o(done_o), .refused_o(refused_o)
);

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
    localparam int S = 48, W = 16, G = 48, H = 48, NM = 5, NK = 25;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, inh = 1'b0, vfy = 1'b0;
    logic [1:0]  tgt = 2'd0;
    logic [13:0] addr = '0;
    logic [7:0]  data = '0;
    logic [13:0] addr_o;
    logic [7:0]  data_o;
    logic [2:0]  mode_o;
    logic vpp_en_o, prog_n_o, vfy_rd_n_o, busy_o, done_o, refused_o;
    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    prog_sequencer #(
        .ADDR_W(14), .DATA_W(8), .SETUP_CYC(S), .PULSE_CYC(W), .GAP_CYC(G),
        .HOLD_CYC(H), .MAIN_PULSES(NM), .KEY_PULSES(NK)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start), .tgt_i(tgt), .lock_inhibit_i(inh),
        .addr_i(addr), .data_i(data), .vfy_req_i(vfy), .addr_o(addr_o), .data_o(data_o),
        .mode_o(mode_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .vfy_rd_n_o(vfy_rd_n_o),
        .busy_o(busy_o), .done_o(done_o), .refused_o(refused_o)
    );

    // {addr 14, data 8, target 2, inhibit 1, refuse expected 1, pulses 5}
    localparam int NV = 8;
    localparam logic [30:0] VEC [NV] = '{
        {14'h0000, 8'hA5, 2'd0, 1'b0, 1'b0, 5'd5},
        {14'h3FFF, 8'h00, 2'd0, 1'b0, 1'b0, 5'd5},
        {14'h0030, 8'h5A, 2'd1, 1'b0, 1'b0, 5'd25},
        {14'h1234, 8'hFF, 2'd2, 1'b0, 1'b0, 5'd25},
        {14'h0ABC, 8'h3C, 2'd0, 1'b1, 1'b1, 5'd0},
        {14'h0011, 8'h11, 2'd3, 1'b0, 1'b1, 5'd0},
        {14'h2AAA, 8'h55, 2'd2, 1'b1, 1'b1, 5'd0},
        {14'h1555, 8'hC3, 2'd1, 1'b0, 1'b0, 5'd25}
    };

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_mode(input logic [1:0] t);
        return (t == 2'd0) ? 3'b001 : (t == 2'd1) ? 3'b010 : 3'b100;
    endfunction

    task automatic run_prog(input logic [13:0] a, input logic [7:0] d, input logic [1:0] t,
                            input logic ih, input logic ex_ref, input int np, input logic poke);
        int busy_n = 0, pre = 0, ramp = 0, pulses = 0, cur_low = 0, cur_high = 0;
        int w_err = 0, g_err = 0, hold_err = 0, vpp_err = 0, mode_err = 0, guard = 0, q = 0;
        logic seen_vpp = 1'b0, prev_n = 1'b1;
        @(negedge clk);
        addr = a; data = d; tgt = t; inh = ih; start = 1'b1;
        @(negedge clk);
        start = 1'b0; inh = 1'b0;
        if (ex_ref) begin
            chk("R9 refused pulse", int'(refused_o), 1);
            chk("R9 busy after refusal", int'(busy_o), 0);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (vpp_en_o || !prog_n_o || busy_o || refused_o) q++;
            end
            chk("R9 quiet after refusal", q, 0);
            return;
        end
        while (!done_o && guard < 5000) begin
            guard++;
            if (poke && busy_n == 60) begin start = 1'b1; addr = ~a; data = ~d; tgt = 2'd1; end
            else if (poke && busy_n == 61) start = 1'b0;
            if (busy_o) busy_n++;
            if (addr_o != a || data_o != d) hold_err++;
            if (mode_o != exp_mode(t)) mode_err++;
            if (!prog_n_o && !vpp_en_o) vpp_err++;
            if (vpp_en_o) begin
                seen_vpp = 1'b1;
                if (prog_n_o) begin
                    if (pulses == 0) ramp++; else cur_high++;
                end
            end else if (!seen_vpp && busy_o) pre++;
            if (!prog_n_o) begin
                if (prev_n) begin
                    pulses++;
                    if (pulses > 1 && cur_high != G) g_err++;
                    cur_high = 0; cur_low = 0;
                end
                cur_low++;
            end else if (!prev_n && cur_low != W) w_err++;
            prev_n = prog_n_o;
            @(negedge clk);
        end
        if (busy_o) busy_n++;
        chk("R7 done seen", int'(done_o), 1);
        chk("R2 setup before vpp", pre, S);
        chk("R2 vpp before first pulse", ramp, S);
        chk((np == NM) ? "R3 pulse count" : "R4 pulse count", pulses, np);
        chk("R5 pulse width errors", w_err, 0);
        chk("R5 gap errors", g_err, 0);
        chk("R6 vpp hold after last pulse", cur_high, H);
        chk("R6 vpp missing under pulse", vpp_err, 0);
        chk(poke ? "R8 latched values kept" : "R6 latched values kept", hold_err, 0);
        chk("R11 mode code", mode_err, 0);
        chk("R7 busy length", busy_n, 2 * S + np * W + (np - 1) * G + H + 1);
        @(negedge clk);
        chk("R7 done one cycle", int'(done_o), 0);
        chk("R7 idle after done", int'(busy_o) + int'(vpp_en_o) + int'(mode_o != 0), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 vpp", int'(vpp_en_o), 0);
        chk("R1 prog_n", int'(prog_n_o), 1);
        chk("R1 read strobe", int'(vfy_rd_n_o), 1);
        chk("R1 done/refused/mode", int'(done_o) + int'(refused_o) + int'(mode_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_prog(VEC[i][30:17], VEC[i][16:9], VEC[i][8:7], VEC[i][6], VEC[i][5],
                     int'(VEC[i][4:0]), 1'b0);

        // R8: a second start mid-sequence is ignored
        run_prog(14'h0777, 8'h81, 2'd0, 1'b0, 1'b0, NM, 1'b1);

        // R10: verify strobe
        @(negedge clk);
        addr = 14'h2468; vfy = 1'b1;
        @(negedge clk);
        vfy = 1'b0;
        chk("R10 read strobe low", int'(vfy_rd_n_o), 0);
        chk("R10 verify address", int'(addr_o), 'h2468);
        chk("R10 no vpp", int'(vpp_en_o), 0);
        @(negedge clk);
        chk("R10 strobe one cycle", int'(vfy_rd_n_o), 1);

        // R1: reset in mid-sequence returns to idle
        @(negedge clk);
        addr = 14'h0100; tgt = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (120) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run busy", int'(busy_o), 0);
        chk("R1 reset mid-run vpp/prog", int'(vpp_en_o) + int'(!prog_n_o), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule